// File: doc/BRIEF.md
# Display Command Byte Decoder

This block sits behind a serial byte receiver in a small graphic panel controller. Each received byte arrives with a select level that marks it as pixel data or as part of a command. The block passes pixel data on to the write addresser. It assembles command bytes into complete commands: an opcode, then as many argument bytes as that opcode needs, from none to eight. A command changes the outputs only on the edge that accepts its last byte.

Two commands set the drawing window: one sets the column bounds and one sets the row bounds. One command loads an 8-bit address-remap register, which the write addresser reads. Its bit 0 swaps columns, bit 1 swaps nibbles, bit 2 selects vertical increment, bit 4 swaps the common lines and bit 6 splits them. Commands for contrast, drive current, timing, precharge, clocking, display on/off and the grey-level table consume their bytes and have no effect. An opcode the decoder does not know raises a one-cycle error pulse. Releasing chip select abandons any partly received command.

Top module: `pcd_decoder`

## Requirements
- R1: After synchronous reset the column window is 0..63, the row window is 0..79, the remap register is 0x00, and both `cmd_err_o` and `pix_valid_o` are low.
- R2: An accepted byte with `dc_sel` high appears on `pix_byte_o` with `pix_valid_o` high one cycle later. It does not advance or clear a pending command.
- R3: Opcode 0x15 takes two argument bytes, column start then column end, each reduced modulo 64. The window does not change until the second argument has been accepted.
- R4: Opcode 0x75 takes two argument bytes, row start then row end, each reduced modulo 80.
- R5: Opcode 0xA0 takes one argument byte, which is stored whole in the remap register.
- R6: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one argument byte and change no output.
- R7: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 complete on the opcode byte itself. The next command byte is an opcode.
- R8: Opcode 0xB8 consumes exactly eight argument bytes and changes no output.
- R9: Opcode 0xFF completes at once, with no effect and no error.
- R10: Any other opcode drives `cmd_err_o` high for exactly one cycle, in the cycle after the opcode byte is accepted. It completes at once, so the next command byte is an opcode.
- R11: A cycle with `cs_active` low discards any partly received command. The next command byte is then an opcode.
- R12: A byte with `byte_valid` low, or one presented while `cs_active` is low, changes no output.
- R13: Pixel-data bytes that arrive between the bytes of a command leave that command intact. It completes with its own arguments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select; low clears the command byte counter |
| dc_sel | input | 1 | 1 = pixel data byte, 0 = command byte |
| byte_valid | input | 1 | Byte strobe from the serial receiver |
| byte_in | input | 8 | Received byte |
| col_start_o | output | 6 | Column window start |
| col_end_o | output | 6 | Column window end |
| row_start_o | output | 7 | Row window start |
| row_end_o | output | 7 | Row window end |
| remap_o | output | 8 | Address remap register |
| cmd_err_o | output | 1 | One-cycle pulse for an unknown opcode |
| pix_valid_o | output | 1 | Pixel byte valid toward the write addresser |
| pix_byte_o | output | 8 | Pixel byte toward the write addresser |

## Verification
Every output comes from a register, so each result appears exactly one cycle after the edge that accepts the byte causing it. This covers the window and remap after a final argument, the error pulse after an unknown opcode and the pixel echo after a data byte. The bench drives each byte on a falling edge and compares all outputs at the next falling edge, half a cycle after the capturing edge, against a byte-level model. Because the error pulse must drop again on the following edge, an idle step after an unknown opcode confirms that the pulse lasts one cycle.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int BYTE_W    = 8;
    localparam int COL_W     = 6;
    localparam int ROW_W     = 7;
    localparam int ROW_LIMIT = 80;
    localparam int COL_LAST  = (1 << COL_W) - 1;
    localparam int ROW_LAST  = ROW_LIMIT - 1;
    localparam int MAX_ARGS  = 8;
    localparam int CNT_W     = $clog2(MAX_ARGS + 1);
    localparam int WRAP_STEPS = (1 << BYTE_W) / ROW_LIMIT + 1;

    typedef enum logic [2:0] {
        OPK_SKIP,
        OPK_COLWIN,
        OPK_ROWWIN,
        OPK_REMAP,
        OPK_UNKNOWN
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [CNT_W-1:0] nargs;
    } op_info_t;

    typedef struct packed {
        logic              fire;
        op_kind_e          kind;
        logic [BYTE_W-1:0] first;
        logic [BYTE_W-1:0] last;
    } cmd_event_t;

    typedef struct packed {
        logic [COL_W-1:0]  col_start;
        logic [COL_W-1:0]  col_end;
        logic [ROW_W-1:0]  row_start;
        logic [ROW_W-1:0]  row_end;
        logic [BYTE_W-1:0] remap;
    } win_state_t;

    localparam win_state_t WIN_RESET = '{
        col_start: '0,
        col_end:   COL_W'(COL_LAST),
        row_start: '0,
        row_end:   ROW_W'(ROW_LAST),
        remap:     '0
    };

    function automatic op_info_t classify(input logic [BYTE_W-1:0] op);
        op_info_t r;
        r.kind  = OPK_SKIP;
        r.nargs = '0;
        case (op)
            8'h15: begin r.kind = OPK_COLWIN; r.nargs = CNT_W'(2); end
            8'h75: begin r.kind = OPK_ROWWIN; r.nargs = CNT_W'(2); end
            8'hA0: begin r.kind = OPK_REMAP;  r.nargs = CNT_W'(1); end
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                r.nargs = CNT_W'(1);
            8'hB8:
                r.nargs = CNT_W'(MAX_ARGS);
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3, 8'hFF:
                r.nargs = '0;
            default: r.kind = OPK_UNKNOWN;
        endcase
        return r;
    endfunction

    function automatic logic [ROW_W-1:0] row_wrap(input logic [BYTE_W-1:0] v);
        int t;
        t = int'(v);
        for (int i = 0; i < WRAP_STEPS; i++) begin
            if (t >= ROW_LIMIT) t = t - ROW_LIMIT;
        end
        return ROW_W'(t);
    endfunction

endpackage

// File: rtl/pcd_classify.sv
module pcd_classify
    import pcd_pkg::*;
(
    input  logic [BYTE_W-1:0] op_byte,
    output op_info_t          info
);
    always_comb begin
        info = classify(op_byte);
    end
endmodule

// File: rtl/pcd_sequencer.sv
module pcd_sequencer
    import pcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              cmd_strobe,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  op_info_t          info,
    output cmd_event_t        evt,
    output logic              err_q
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nargs_q;
    op_kind_e          kind_q;
    logic [BYTE_W-1:0] first_q;

    logic              at_opcode;
    logic              is_unknown;
    logic              finishing;
    logic              starting;

    always_comb begin
        at_opcode  = (cnt_q == '0);
        is_unknown = at_opcode && (info.kind == OPK_UNKNOWN);
        starting   = cmd_strobe && at_opcode && !is_unknown && (info.nargs != '0);
        finishing  = cmd_strobe && !at_opcode && (cnt_q == nargs_q);

        evt       = '0;
        evt.kind  = OPK_SKIP;
        if (finishing) begin
            evt.fire  = 1'b1;
            evt.kind  = kind_q;
            evt.first = (cnt_q == CNT_W'(1)) ? cmd_byte : first_q;
            evt.last  = cmd_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            nargs_q <= '0;
            kind_q  <= OPK_SKIP;
            first_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= cmd_strobe && is_unknown;
            if (!cs_active) begin
                cnt_q <= '0;
            end else if (starting) begin
                cnt_q   <= CNT_W'(1);
                nargs_q <= info.nargs;
                kind_q  <= info.kind;
            end else if (finishing) begin
                cnt_q <= '0;
            end else if (cmd_strobe && !at_opcode) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (cmd_strobe && cnt_q == CNT_W'(1)) begin
                first_q <= cmd_byte;
            end
        end
    end
endmodule

// File: rtl/pcd_apply.sv
module pcd_apply
    import pcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_event_t evt,
    output win_state_t state_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_RESET;
        end else if (evt.fire) begin
            case (evt.kind)
                OPK_COLWIN: begin
                    state_q.col_start <= evt.first[COL_W-1:0];
                    state_q.col_end   <= evt.last[COL_W-1:0];
                end
                OPK_ROWWIN: begin
                    state_q.row_start <= row_wrap(evt.first);
                    state_q.row_end   <= row_wrap(evt.last);
                end
                OPK_REMAP: begin
                    state_q.remap <= evt.last;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcd_pixel_path.sv
module pcd_pixel_path
    import pcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_strobe,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              pix_valid_q,
    output logic [BYTE_W-1:0] pix_byte_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid_q <= 1'b0;
            pix_byte_q  <= '0;
        end else begin
            pix_valid_q <= pix_strobe;
            if (pix_strobe) pix_byte_q <= byte_in;
        end
    end
endmodule

// File: rtl/pcd_decoder.sv
module pcd_decoder
    import pcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_active,
    input  logic              dc_sel,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [COL_W-1:0]  col_start_o,
    output logic [COL_W-1:0]  col_end_o,
    output logic [ROW_W-1:0]  row_start_o,
    output logic [ROW_W-1:0]  row_end_o,
    output logic [BYTE_W-1:0] remap_o,
    output logic              cmd_err_o,
    output logic              pix_valid_o,
    output logic [BYTE_W-1:0] pix_byte_o
);
    logic       accepted;
    logic       cmd_strobe;
    logic       pix_strobe;
    op_info_t   info;
    cmd_event_t evt;
    win_state_t state;

    always_comb begin
        accepted   = byte_valid && cs_active;
        cmd_strobe = accepted && !dc_sel;
        pix_strobe = accepted && dc_sel;
    end

    pcd_classify u_classify (
        .op_byte (byte_in),
        .info    (info)
    );

    pcd_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .cs_active  (cs_active),
        .cmd_strobe (cmd_strobe),
        .cmd_byte   (byte_in),
        .info       (info),
        .evt        (evt),
        .err_q      (cmd_err_o)
    );

    pcd_apply u_apply (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .state_q (state)
    );

    pcd_pixel_path u_pix (
        .clk         (clk),
        .rst         (rst),
        .pix_strobe  (pix_strobe),
        .byte_in     (byte_in),
        .pix_valid_q (pix_valid_o),
        .pix_byte_q  (pix_byte_o)
    );

    always_comb begin
        col_start_o = state.col_start;
        col_end_o   = state.col_end;
        row_start_o = state.row_start;
        row_end_o   = state.row_end;
        remap_o     = state.remap;
    end
endmodule

// File: rtl/pcd_decoder_chk.sv
module pcd_decoder_chk
    import pcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_active,
    input logic              dc_sel,
    input logic              byte_valid,
    input logic [BYTE_W-1:0] byte_in,
    input logic [COL_W-1:0]  col_start_o,
    input logic [COL_W-1:0]  col_end_o,
    input logic [ROW_W-1:0]  row_start_o,
    input logic [ROW_W-1:0]  row_end_o,
    input logic [BYTE_W-1:0] remap_o,
    input logic              cmd_err_o,
    input logic              pix_valid_o,
    input logic [BYTE_W-1:0] pix_byte_o
);
    AST_PIX_ECHO: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o |-> ($past(byte_valid && cs_active && dc_sel) && pix_byte_o == $past(byte_in))); // R2

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(row_start_o) < ROW_LIMIT) && (int'(row_end_o) < ROW_LIMIT)); // R4

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cmd_err_o |-> $past(byte_valid && cs_active && !dc_sel)); // R10

    AST_ERR_NOT_PIX: assert property (@(posedge clk) disable iff (rst)
        cmd_err_o |-> !pix_valid_o); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_valid && cs_active && !dc_sel) |->
            ($stable(col_start_o) && $stable(col_end_o) && $stable(row_start_o)
             && $stable(row_end_o) && $stable(remap_o))); // R12

    AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(cs_active) |-> ($stable(remap_o) && !cmd_err_o)); // R11
endmodule

bind pcd_decoder pcd_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_active   (cs_active),
    .dc_sel      (dc_sel),
    .byte_valid  (byte_valid),
    .byte_in     (byte_in),
    .col_start_o (col_start_o),
    .col_end_o   (col_end_o),
    .row_start_o (row_start_o),
    .row_end_o   (row_end_o),
    .remap_o     (remap_o),
    .cmd_err_o   (cmd_err_o),
    .pix_valid_o (pix_valid_o),
    .pix_byte_o  (pix_byte_o)
);

// File: tb/pcd_decoder_tb_top.sv
`timescale 1ns/1ps
module pcd_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_active = 1'b1;
    logic       dc_sel = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic [5:0] col_start_o, col_end_o;
    logic [6:0] row_start_o, row_end_o;
    logic [7:0] remap_o, pix_byte_o;
    logic       cmd_err_o, pix_valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model
    int m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79, m_rm = 0;
    int m_cnt = 0, m_op = 0, m_a0 = 0;
    int e_err = 0, e_pv = 0, e_pb = 0;

    always #5 clk = ~clk;

    pcd_decoder dut_i (
        .clk (clk), .rst (rst), .cs_active (cs_active), .dc_sel (dc_sel),
        .byte_valid (byte_valid), .byte_in (byte_in),
        .col_start_o (col_start_o), .col_end_o (col_end_o),
        .row_start_o (row_start_o), .row_end_o (row_end_o),
        .remap_o (remap_o), .cmd_err_o (cmd_err_o),
        .pix_valid_o (pix_valid_o), .pix_byte_o (pix_byte_o)
    );

    function automatic int exp_args(input int op);
        case (op)
            'h15, 'h75: return 2;
            'hA0, 'h81, 'hA1, 'hA2, 'hA8, 'hAD, 'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: return 1;
            'h84, 'h85, 'h86, 'hA4, 'hA5, 'hA6, 'hA7, 'hAE, 'hAF, 'hE3, 'hFF: return 0;
            'hB8: return 8;
            default: return -1;
        endcase
    endfunction

    task automatic cmp(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic model_byte(input bit v, input bit dc, input bit cs, input int b);
        int n;
        e_err = 0;
        e_pv  = 0;
        if (!cs) begin
            m_cnt = 0;
        end else if (v && dc) begin
            e_pv = 1;
            e_pb = b;
        end else if (v) begin
            if (m_cnt == 0) begin
                n = exp_args(b);
                if (n < 0) e_err = 1;
                else if (n > 0) begin m_op = b; m_cnt = 1; end
            end else begin
                n = exp_args(m_op);
                if (m_cnt == 1) m_a0 = b;
                if (m_cnt == n) begin
                    if (m_op == 'h15) begin m_cs = m_a0 % 64; m_ce = b % 64; end
                    if (m_op == 'h75) begin m_rs = m_a0 % 80; m_re = b % 80; end
                    if (m_op == 'hA0) m_rm = b;
                    m_cnt = 0;
                end else m_cnt++;
            end
        end
    endtask

    task automatic compare_all();
        cmp("R3 col_start", int'(col_start_o), m_cs);
        cmp("R3 col_end", int'(col_end_o), m_ce);
        cmp("R4 row_start", int'(row_start_o), m_rs);
        cmp("R4 row_end", int'(row_end_o), m_re);
        cmp("R5 remap", int'(remap_o), m_rm);
        cmp("R10 cmd_err", int'(cmd_err_o), e_err);
        cmp("R2 pix_valid", int'(pix_valid_o), e_pv);
        if (e_pv != 0) cmp("R2 pix_byte", int'(pix_byte_o), e_pb);
    endtask

    // one clock: drive at a falling edge, compare at the next falling edge
    task automatic step(input bit v, input bit dc, input bit cs, input int b);
        byte_valid = v;
        dc_sel     = dc;
        cs_active  = cs;
        byte_in    = 8'(b);
        model_byte(v, dc, cs, b);
        @(negedge clk);
        byte_valid = 1'b0;
        cs_active  = 1'b1;
        compare_all();
    endtask

    task automatic cmd(input int b);  step(1'b1, 1'b0, 1'b1, b); endtask
    task automatic dat(input int b);  step(1'b1, 1'b1, 1'b1, b); endtask
    task automatic idle();            step(1'b0, 1'b0, 1'b1, 0); endtask

    int pool [24] = '{'h15, 'h75, 'hA0, 'h81, 'hA1, 'hA2, 'hA8, 'hAD, 'hB1, 'hB2,
                      'hB3, 'hBC, 'hBE, 'hBF, 'h84, 'hA5, 'hAE, 'hE3, 'hFF, 'hB8,
                      'h00, 'h42, 'h14, 'hA3};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog R1..R13 run actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cmp("R1 col_start", int'(col_start_o), 0);
        cmp("R1 col_end", int'(col_end_o), 63);
        cmp("R1 row_start", int'(row_start_o), 0);
        cmp("R1 row_end", int'(row_end_o), 79);
        cmp("R1 remap", int'(remap_o), 0);
        cmp("R1 cmd_err", int'(cmd_err_o), 0);
        cmp("R1 pix_valid", int'(pix_valid_o), 0);

        // R2 pixel echo
        dat('hC3);
        cmp("R2 echo byte", int'(pix_byte_o), 'hC3);

        // R3 column window, modulo 64, only on final byte
        cmd('h15); cmd('h45);
        cmp("R3 col_start held before last arg", int'(col_start_o), 0);
        cmd('h7F);
        cmp("R3 col_start mod 64", int'(col_start_o), 5);
        cmp("R3 col_end mod 64", int'(col_end_o), 63);

        // R4 row window, modulo 80
        cmd('h75); cmd('hA5); cmd('h9F);
        cmp("R4 row_start mod 80", int'(row_start_o), 5);
        cmp("R4 row_end mod 80", int'(row_end_o), 79);

        // R5 remap
        cmd('hA0); cmd('h57);
        cmp("R5 remap stored", int'(remap_o), 'h57);

        // R6 one ignored argument
        cmd('h81); cmd('hA0); cmd('hA0); cmd('h55);
        cmp("R6 one arg consumed", int'(remap_o), 'h55);
        cmd('hBF); cmd('h15); cmd('hA0); cmd('h5A);
        cmp("R6 last ignored opcode", int'(remap_o), 'h5A);

        // R7 no-argument opcodes
        cmd('hAE); cmd('hA0); cmd('h12);
        cmp("R7 zero-arg opcode", int'(remap_o), 'h12);
        cmd('hE3); cmd('hA0); cmd('h13);
        cmp("R7 nop opcode", int'(remap_o), 'h13);

        // R8 grey table takes eight bytes
        cmd('hB8);
        for (int i = 0; i < 8; i++) cmd('hA0);
        cmd('hA0); cmd('h33);
        cmp("R8 eight args consumed", int'(remap_o), 'h33);

        // R9 0xFF
        cmd('hFF);
        cmp("R9 no error on FF", int'(cmd_err_o), 0);
        cmd('hA0); cmd('h66);
        cmp("R9 FF ends at once", int'(remap_o), 'h66);

        // R10 unknown opcode
        cmd('h42);
        cmp("R10 err pulse", int'(cmd_err_o), 1);
        idle();
        cmp("R10 err one cycle", int'(cmd_err_o), 0);
        cmd('h00); cmd('hA0); cmd('h77);
        cmp("R10 next byte is opcode", int'(remap_o), 'h77);

        // R11 chip select abandons a partial command
        cmd('h15); cmd('h05);
        step(1'b0, 1'b0, 1'b0, 0);
        cmd('hA0); cmd('h44);
        cmp("R11 remap after cs drop", int'(remap_o), 'h44);
        cmp("R11 col window unchanged", int'(col_end_o), 63);

        // R12 invalid or deselected bytes ignored
        step(1'b0, 1'b0, 1'b1, 'hA0);
        step(1'b1, 1'b0, 1'b0, 'hA0);
        cmd('hA0); cmd('h22);
        cmp("R12 ignored bytes", int'(remap_o), 'h22);

        // R13 data inside a command
        cmd('h15); cmd('h03); dat('hEE);
        cmp("R13 pix during command", int'(pix_byte_o), 'hEE);
        cmd('h09);
        cmp("R13 col_start", int'(col_start_o), 3);
        cmp("R13 col_end", int'(col_end_o), 9);

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 11));
            case (r)
                0, 1: dat(int'($urandom_range(0, 255)));
                2:    step(1'b0, 1'($urandom_range(0, 1)), 1'b1, int'($urandom_range(0, 255)));
                3:    step(1'b1, 1'($urandom_range(0, 1)), 1'b0, int'($urandom_range(0, 255)));
                default: begin
                    if (m_cnt == 0) cmd(pool[$urandom_range(0, 23)]);
                    else cmd(int'($urandom_range(0, 255)));
                end
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule